// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This block sits between a register bus and a serial shift engine of an SPI controller. It holds one transmit and one receive word FIFO, counts their fill levels, compares those levels against programmable thresholds, and turns the result into status flags, maskable interrupts and DMA request lines. A bus write to the transmit data port pushes a word. A bus read of the receive data port pops a word. The engine drains the transmit FIFO and fills the receive FIFO through its own strobes.

Interrupt sources are of two kinds. Overflow and underflow are latched events that stay set until they are cleared. The two threshold sources follow the live FIFO level. A single clear register can remove all latched events at once or one at a time. Raw, masked and combined interrupt outputs are all registered. A controller enable bit gates all traffic. While it is low, both FIFOs are held empty.

Top module: `spi_fifo_irq`

## Requirements
- R1: After reset every register reads 0, both levels are 0, STATUS (word 7) reads 0x0C, and irq, irq_raw, irq_masked and both DMA requests are 0. Word addresses: 0 CTRL, 1 TXDATA, 2 RXDATA, 3 TXTHR, 4 RXTHR, 5 TXLVL, 6 RXLVL, 7 STATUS, 8 MASK, 9 RAW, 10 MASKED, 11 CLEAR, 12 DMAEN, 13 DMATXLVL, 14 DMARXLVL. Read data appears on bus_rdata one cycle after the bus_rd strobe.
- R2: While enabled, each write to TXDATA adds one word and TXLVL counts the words. STATUS bit 1 (tx full) is set at DEPTH words and bit 2 (tx empty) at zero words. The engine receives the words in write order on eng_tx_data and pops them with eng_tx_pop.
- R3: A write to TXDATA when the transmit FIFO is full is dropped, leaves TXLVL at DEPTH and sets raw bit 1 (tx overflow).
- R4: Each eng_rx_push adds a word. A read of RXDATA returns the oldest word and lowers RXLVL by one. STATUS bit 3 is rx empty and bit 4 is rx full.
- R5: A read of RXDATA while the receive FIFO is empty returns 0 and sets raw bit 2 (rx underflow). An engine push into a full receive FIFO is dropped and sets raw bit 3 (rx overflow).
- R6: Raw bit 0 is set while enabled and TXLVL <= TXTHR. Raw bit 4 is set while enabled and RXLVL > RXTHR. Both follow the level and cannot be cleared.
- R7: Each threshold and DMA level register keeps only the low log2(DEPTH) bits of the written value. With DEPTH 16, writing 16 reads back 0 and writing 15 reads back 15.
- R8: A write to CLEAR removes latched events. Bit 0 clears all of them, bit 1 clears rx underflow, bit 2 clears rx overflow and bit 3 clears tx overflow. An event that occurs in the same cycle as its clear stays set.
- R9: irq_masked equals raw AND MASK (word 8, raw bit layout), and irq is the OR of irq_masked. MASKED (word 10) reads the same value.
- R10: DMAEN bit 1 enables dma_tx_req, which is high while TXLVL <= DMATXLVL. DMAEN bit 0 enables dma_rx_req, which is high while RXLVL > DMARXLVL. Both requests need the controller enabled.
- R11: CTRL bit 0 enables the controller. While it is 0, both FIFOs are empty, and bus pushes, bus pops and engine strobes are ignored without raising any event.
- R12: STATUS bit 0 (busy) is set while enabled and either eng_busy is high or the transmit FIFO holds data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data, registered |
| eng_busy | input | 1 | Serial engine is shifting |
| eng_tx_pop | input | 1 | Engine takes the head transmit word |
| eng_tx_data | output | W | Head of the transmit FIFO |
| eng_tx_avail | output | 1 | Transmit FIFO holds data and the controller is enabled |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_data | input | W | Received word |
| irq_raw | output | 5 | Raw interrupt status |
| irq_masked | output | 5 | Masked interrupt status |
| irq | output | 1 | Combined interrupt |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |

## Verification
The bench probes the edges of both FIFOs. It overfills the transmit FIFO, which a design without a full check would show as a wrapped level or a corrupted head word. It pops an empty receive FIFO, which a design without an empty check would answer with stale data and no underflow flag. It also confirms that each clear bit removes exactly its own event, that the threshold bits survive a clear-all, and that an overflow arriving together with its clear remains visible. A wrong priority between set and clear would lose that event. It writes DEPTH and DEPTH-1 to the threshold to expose a register that is too wide, and it drives traffic while the controller is disabled, which a leaky gate would turn into nonzero levels or spurious events.

// File: rtl/sfi_pkg.sv
package sfi_pkg;
  localparam int IRQ_N = 5;
  localparam int CLR_N = 4;

  // interrupt bit positions (shared by raw, mask and masked)
  localparam int IB_TX_THR = 0;
  localparam int IB_TX_OVF = 1;
  localparam int IB_RX_UDF = 2;
  localparam int IB_RX_OVF = 3;
  localparam int IB_RX_THR = 4;

  // clear register bits
  localparam int CB_ALL    = 0;
  localparam int CB_RX_UDF = 1;
  localparam int CB_RX_OVF = 2;
  localparam int CB_TX_OVF = 3;

  // register word addresses
  localparam logic [3:0] A_CTRL   = 4'd0;
  localparam logic [3:0] A_TXD    = 4'd1;
  localparam logic [3:0] A_RXD    = 4'd2;
  localparam logic [3:0] A_TXTHR  = 4'd3;
  localparam logic [3:0] A_RXTHR  = 4'd4;
  localparam logic [3:0] A_TXLVL  = 4'd5;
  localparam logic [3:0] A_RXLVL  = 4'd6;
  localparam logic [3:0] A_STAT   = 4'd7;
  localparam logic [3:0] A_MASK   = 4'd8;
  localparam logic [3:0] A_RAW    = 4'd9;
  localparam logic [3:0] A_MSKD   = 4'd10;
  localparam logic [3:0] A_CLR    = 4'd11;
  localparam logic [3:0] A_DMAEN  = 4'd12;
  localparam logic [3:0] A_DTXLVL = 4'd13;
  localparam logic [3:0] A_DRXLVL = 4'd14;
endpackage

// File: rtl/sfi_fifo.sv
module sfi_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  pop_data,
  output logic [CW-1:0] level,
  output logic          full,
  output logic          empty,
  output logic          push_drop,
  output logic          pop_miss
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          push_ok, pop_ok;

  assign full      = (count == CW'(DEPTH));
  assign empty     = (count == '0);
  assign push_ok   = push & ~full;
  assign pop_ok    = pop & ~empty;
  assign push_drop = push & full;
  assign pop_miss  = pop & empty;
  assign level     = count;
  assign pop_data  = mem[rptr];

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
      if (pop_ok)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  a_r3_drop_keeps_level: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !flush) |=> (level == $past(level)));
  a_r5_miss_keeps_empty: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push && !flush) |=> empty);
  a_r11_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> empty);
endmodule

// File: rtl/sfi_events.sv
module sfi_events
  import sfi_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_thr_hit,
  input  logic             rx_thr_hit,
  input  logic             tx_ovf,
  input  logic             rx_udf,
  input  logic             rx_ovf,
  input  logic [CLR_N-1:0] clr,
  input  logic [IRQ_N-1:0] mask,
  output logic [IRQ_N-1:0] raw_now,
  output logic [IRQ_N-1:0] raw_q,
  output logic [IRQ_N-1:0] masked_q,
  output logic             irq_q
);
  logic [IB_RX_OVF:IB_TX_OVF] ev_set, ev_clr, sticky_q;

  assign ev_set[IB_TX_OVF] = tx_ovf;
  assign ev_set[IB_RX_UDF] = rx_udf;
  assign ev_set[IB_RX_OVF] = rx_ovf;

  assign ev_clr[IB_TX_OVF] = clr[CB_ALL] | clr[CB_TX_OVF];
  assign ev_clr[IB_RX_UDF] = clr[CB_ALL] | clr[CB_RX_UDF];
  assign ev_clr[IB_RX_OVF] = clr[CB_ALL] | clr[CB_RX_OVF];

  // latched events: a new event beats a clear in the same cycle
  for (genvar i = IB_TX_OVF; i <= IB_RX_OVF; i++) begin : g_sticky
    always_ff @(posedge clk) begin
      if (rst)               sticky_q[i] <= 1'b0;
      else if (ev_set[i])    sticky_q[i] <= 1'b1;
      else if (ev_clr[i])    sticky_q[i] <= 1'b0;
    end

    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
      ev_set[i] |=> ##1 raw_q[i]);
  end

  always_comb begin
    raw_now                        = '0;
    raw_now[IB_TX_THR]             = tx_thr_hit;
    raw_now[IB_RX_THR]             = rx_thr_hit;
    raw_now[IB_RX_OVF:IB_TX_OVF]   = sticky_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q    <= '0;
      masked_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      raw_q    <= raw_now;
      masked_q <= raw_now & mask;
      irq_q    <= |(raw_now & mask);
    end
  end

  a_r8_clear_all: assert property (@(posedge clk) disable iff (rst)
    (clr[CB_ALL] && !tx_ovf && !rx_udf && !rx_ovf) |=> ##1 (raw_q[IB_RX_OVF:IB_TX_OVF] == '0));
  a_r9_irq_is_or: assert property (@(posedge clk) disable iff (rst)
    irq_q == |masked_q);
  a_r9_masked_in_raw: assert property (@(posedge clk) disable iff (rst)
    (masked_q & ~raw_q) == '0);
endmodule

// File: rtl/sfi_lvl_cmp.sv
module sfi_lvl_cmp #(
  parameter int LW    = 5,
  parameter int TW    = 4,
  parameter bit ABOVE = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [LW-1:0] level,
  input  logic [TW-1:0] thr,
  output logic          req
);
  logic hit;

  // ABOVE picks "level exceeds thr", otherwise "level at or below thr"
  if (ABOVE) begin : g_above
    assign hit = level > LW'(thr);
  end else begin : g_below
    assign hit = level <= LW'(thr);
  end

  always_ff @(posedge clk) begin
    if (rst) req <= 1'b0;
    else     req <= en & hit;
  end

  a_r10_req_needs_en: assert property (@(posedge clk) disable iff (rst)
    req |-> $past(en));
endmodule

// File: rtl/spi_fifo_irq.sv
module spi_fifo_irq
  import sfi_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  parameter int BUS_W = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [3:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             eng_busy,
  input  logic             eng_tx_pop,
  output logic [W-1:0]     eng_tx_data,
  output logic             eng_tx_avail,
  input  logic             eng_rx_push,
  input  logic [W-1:0]     eng_rx_data,
  output logic [IRQ_N-1:0] irq_raw,
  output logic [IRQ_N-1:0] irq_masked,
  output logic             irq,
  output logic             dma_tx_req,
  output logic             dma_rx_req
);
  logic             en_q;
  logic [AW-1:0]    tx_thr_q, rx_thr_q, dma_tx_lvl_q, dma_rx_lvl_q;
  logic [IRQ_N-1:0] mask_q;
  logic [1:0]       dma_en_q;
  logic [BUS_W-1:0] rdata_q, rd_mux;

  logic             wr_txd, rd_rxd, wr_clr;
  logic             tx_push, tx_pop, rx_push, rx_pop, flush;
  logic [CW-1:0]    tx_lvl, rx_lvl;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic             tx_ovf_ev, rx_ovf_ev, rx_udf_ev, tx_pop_miss_unused;
  logic [W-1:0]     rx_head;
  logic [CLR_N-1:0] clr_bits;
  logic [IRQ_N-1:0] raw_now;
  logic [4:0]       status;
  logic             tx_thr_hit, rx_thr_hit;
  logic             unused_wdata;

  assign unused_wdata = ^bus_wdata[BUS_W-1:W];

  assign wr_txd  = bus_wr && (bus_addr == A_TXD);
  assign rd_rxd  = bus_rd && (bus_addr == A_RXD);
  assign wr_clr  = bus_wr && (bus_addr == A_CLR);

  assign flush   = ~en_q;
  assign tx_push = en_q & wr_txd;
  assign tx_pop  = en_q & eng_tx_pop;
  assign rx_push = en_q & eng_rx_push;
  assign rx_pop  = en_q & rd_rxd;

  sfi_fifo #(.W(W), .DEPTH(DEPTH)) u_txf (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .push      (tx_push),
    .push_data (bus_wdata[W-1:0]),
    .pop       (tx_pop),
    .pop_data  (eng_tx_data),
    .level     (tx_lvl),
    .full      (tx_full),
    .empty     (tx_empty),
    .push_drop (tx_ovf_ev),
    .pop_miss  (tx_pop_miss_unused)
  );

  sfi_fifo #(.W(W), .DEPTH(DEPTH)) u_rxf (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .push      (rx_push),
    .push_data (eng_rx_data),
    .pop       (rx_pop),
    .pop_data  (rx_head),
    .level     (rx_lvl),
    .full      (rx_full),
    .empty     (rx_empty),
    .push_drop (rx_ovf_ev),
    .pop_miss  (rx_udf_ev)
  );

  assign eng_tx_avail = en_q & ~tx_empty;

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q         <= 1'b0;
      tx_thr_q     <= '0;
      rx_thr_q     <= '0;
      mask_q       <= '0;
      dma_en_q     <= '0;
      dma_tx_lvl_q <= '0;
      dma_rx_lvl_q <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_CTRL:   en_q         <= bus_wdata[0];
        A_TXTHR:  tx_thr_q     <= bus_wdata[AW-1:0];
        A_RXTHR:  rx_thr_q     <= bus_wdata[AW-1:0];
        A_MASK:   mask_q       <= bus_wdata[IRQ_N-1:0];
        A_DMAEN:  dma_en_q     <= bus_wdata[1:0];
        A_DTXLVL: dma_tx_lvl_q <= bus_wdata[AW-1:0];
        A_DRXLVL: dma_rx_lvl_q <= bus_wdata[AW-1:0];
        default:  ;
      endcase
    end
  end

  assign clr_bits   = wr_clr ? bus_wdata[CLR_N-1:0] : '0;
  assign tx_thr_hit = en_q & (tx_lvl <= CW'(tx_thr_q));
  assign rx_thr_hit = en_q & (rx_lvl >  CW'(rx_thr_q));

  sfi_events u_ev (
    .clk        (clk),
    .rst        (rst),
    .tx_thr_hit (tx_thr_hit),
    .rx_thr_hit (rx_thr_hit),
    .tx_ovf     (tx_ovf_ev),
    .rx_udf     (rx_udf_ev),
    .rx_ovf     (rx_ovf_ev),
    .clr        (clr_bits),
    .mask       (mask_q),
    .raw_now    (raw_now),
    .raw_q      (irq_raw),
    .masked_q   (irq_masked),
    .irq_q      (irq)
  );

  sfi_lvl_cmp #(.LW(CW), .TW(AW), .ABOVE(1'b0)) u_dma_tx (
    .clk   (clk),
    .rst   (rst),
    .en    (en_q & dma_en_q[1]),
    .level (tx_lvl),
    .thr   (dma_tx_lvl_q),
    .req   (dma_tx_req)
  );

  sfi_lvl_cmp #(.LW(CW), .TW(AW), .ABOVE(1'b1)) u_dma_rx (
    .clk   (clk),
    .rst   (rst),
    .en    (en_q & dma_en_q[0]),
    .level (rx_lvl),
    .thr   (dma_rx_lvl_q),
    .req   (dma_rx_req)
  );

  // status: {rx full, rx empty, tx empty, tx full, busy}
  assign status = {rx_full, rx_empty, tx_empty, tx_full,
                   en_q & (eng_busy | ~tx_empty)};

  always_comb begin
    case (bus_addr)
      A_CTRL:   rd_mux = BUS_W'(en_q);
      A_RXD:    rd_mux = rx_empty ? '0 : BUS_W'(rx_head);
      A_TXTHR:  rd_mux = BUS_W'(tx_thr_q);
      A_RXTHR:  rd_mux = BUS_W'(rx_thr_q);
      A_TXLVL:  rd_mux = BUS_W'(tx_lvl);
      A_RXLVL:  rd_mux = BUS_W'(rx_lvl);
      A_STAT:   rd_mux = BUS_W'(status);
      A_MASK:   rd_mux = BUS_W'(mask_q);
      A_RAW:    rd_mux = BUS_W'(raw_now);
      A_MSKD:   rd_mux = BUS_W'(raw_now & mask_q);
      A_DMAEN:  rd_mux = BUS_W'(dma_en_q);
      A_DTXLVL: rd_mux = BUS_W'(dma_tx_lvl_q);
      A_DRXLVL: rd_mux = BUS_W'(dma_rx_lvl_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;

  a_r11_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> (tx_lvl == '0 && rx_lvl == '0));
  a_r12_busy_needs_en: assert property (@(posedge clk) disable iff (rst)
    status[0] |-> en_q);
  a_r2_avail_has_data: assert property (@(posedge clk) disable iff (rst)
    eng_tx_avail |-> (tx_lvl != '0));
endmodule

// File: tb/spi_fifo_irq_tb_top.sv
module spi_fifo_irq_tb_top;
  localparam int W     = 16;
  localparam int DEPTH = 16;
  localparam int BUS_W = 32;

  localparam logic [3:0] A_CTRL = 4'd0,  A_TXD = 4'd1,  A_RXD = 4'd2,
                         A_TXTHR = 4'd3, A_RXTHR = 4'd4, A_TXLVL = 4'd5,
                         A_RXLVL = 4'd6, A_STAT = 4'd7, A_MASK = 4'd8,
                         A_RAW = 4'd9,   A_MSKD = 4'd10, A_CLR = 4'd11,
                         A_DMAEN = 4'd12, A_DTXLVL = 4'd13, A_DRXLVL = 4'd14;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]       bus_addr = '0;
  logic [BUS_W-1:0] bus_wdata = '0;
  logic [BUS_W-1:0] bus_rdata;
  logic             eng_busy = 1'b0, eng_tx_pop = 1'b0, eng_rx_push = 1'b0;
  logic [W-1:0]     eng_rx_data = '0;
  logic [W-1:0]     eng_tx_data;
  logic             eng_tx_avail;
  logic [4:0]       irq_raw, irq_masked;
  logic             irq, dma_tx_req, dma_rx_req;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  spi_fifo_irq #(.W(W), .DEPTH(DEPTH), .BUS_W(BUS_W)) dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_busy(eng_busy), .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
    .eng_tx_avail(eng_tx_avail), .eng_rx_push(eng_rx_push),
    .eng_rx_data(eng_rx_data), .irq_raw(irq_raw), .irq_masked(irq_masked),
    .irq(irq), .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic eng_push(input logic [W-1:0] d);
    @(negedge clk);
    eng_rx_push = 1'b1; eng_rx_data = d;
    @(negedge clk);
    eng_rx_push = 1'b0;
  endtask

  task automatic eng_pop(output logic [W-1:0] d);
    @(negedge clk);
    d = eng_tx_data;
    eng_tx_pop = 1'b1;
    @(negedge clk);
    eng_tx_pop = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic drain_rx(input int n);
    logic [31:0] d;
    for (int i = 0; i < n; i++) rd(A_RXD, d);
  endtask

  task automatic drain_tx(input int n);
    logic [W-1:0] d;
    for (int i = 0; i < n; i++) eng_pop(d);
  endtask

  task automatic t_reset();
    settle();
    rd_chk("R1 status", A_STAT, 32'h0C);
    rd_chk("R1 txlvl", A_TXLVL, 0);
    rd_chk("R1 rxlvl", A_RXLVL, 0);
    rd_chk("R1 mask", A_MASK, 0);
    rd_chk("R1 ctrl", A_CTRL, 0);
    chk("R1 irq_raw", irq_raw, 0);
    chk("R1 irq", irq, 0);
    chk("R1 dma", {dma_tx_req, dma_rx_req}, 0);
    wr(A_CTRL, 1);
    rd_chk("R11 ctrl on", A_CTRL, 1);
    settle();
    chk("R6 tx thr at level 0", irq_raw, 32'h01);
  endtask

  task automatic t_tx_fill_overflow();
    logic [W-1:0] d;
    int errs = 0;
    for (int i = 0; i < DEPTH; i++) wr(A_TXD, 32'h100 + i);
    rd_chk("R2 txlvl full", A_TXLVL, DEPTH);
    rd_chk("R2 status full", A_STAT, 32'h0B);
    chk("R2 avail", eng_tx_avail, 1);
    wr(A_TXD, 32'h1FF);
    rd_chk("R3 txlvl after drop", A_TXLVL, DEPTH);
    settle();
    chk("R3 tx overflow bit", irq_raw[1], 1);
    for (int i = 0; i < DEPTH; i++) begin
      eng_pop(d);
      if (d !== W'(32'h100 + i)) errs++;
    end
    chk("R2 engine order", errs, 0);
    rd_chk("R2 txlvl empty", A_TXLVL, 0);
    rd_chk("R2 status empty", A_STAT, 32'h0C);
    settle();
    chk("R3 overflow sticky", irq_raw[1], 1);
  endtask

  task automatic t_rx_path();
    for (int i = 0; i < 3; i++) eng_push(W'(16'hA0 + i));
    rd_chk("R4 rxlvl 3", A_RXLVL, 3);
    rd_chk("R4 first word", A_RXD, 32'hA0);
    rd_chk("R4 rxlvl 2", A_RXLVL, 2);
    rd_chk("R4 second word", A_RXD, 32'hA1);
    rd_chk("R4 third word", A_RXD, 32'hA2);
    rd_chk("R4 rxlvl 0", A_RXLVL, 0);
  endtask

  task automatic t_rx_errors();
    logic [31:0] d;
    rd_chk("R5 empty read zero", A_RXD, 0);
    settle();
    chk("R5 underflow bit", irq_raw[2], 1);
    for (int i = 0; i < DEPTH + 1; i++) eng_push(W'(16'hB0 + i));
    rd_chk("R5 rxlvl capped", A_RXLVL, DEPTH);
    rd_chk("R4 status rx full", A_STAT, 32'h14);
    settle();
    chk("R5 overflow bit", irq_raw[3], 1);
    rd_chk("R4 oldest kept", A_RXD, 32'hB0);
    for (int i = 1; i < DEPTH - 1; i++) rd(A_RXD, d);
    rd_chk("R5 last kept word", A_RXD, 32'hBF);
    rd_chk("R4 rxlvl drained", A_RXLVL, 0);
  endtask

  task automatic t_clear();
    rd_chk("R8 before clear", A_RAW, 32'h0F);
    wr(A_CLR, 32'h2);
    rd_chk("R8 clear rx underflow", A_RAW, 32'h0B);
    wr(A_CLR, 32'h4);
    rd_chk("R8 clear rx overflow", A_RAW, 32'h03);
    wr(A_CLR, 32'h8);
    rd_chk("R8 clear tx overflow", A_RAW, 32'h01);
    rd_chk("R5 underflow again", A_RXD, 0);
    rd_chk("R8 underflow set", A_RAW, 32'h05);
    wr(A_CLR, 32'h1);
    rd_chk("R6 clear-all keeps threshold", A_RAW, 32'h01);
    for (int i = 0; i < DEPTH; i++) eng_push(W'(16'hC0 + i));
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = A_CLR; bus_wdata = 32'h4;
    eng_rx_push = 1'b1; eng_rx_data = 16'hCC;
    @(negedge clk);
    bus_wr = 1'b0; eng_rx_push = 1'b0;
    settle();
    chk("R8 set wins over clear", irq_raw[3], 1);
    rd_chk("R8 raw with overflow", A_RAW, 32'h19);
    wr(A_CLR, 32'h4);
    rd_chk("R8 overflow cleared", A_RAW, 32'h11);
    drain_rx(DEPTH);
    rd_chk("R6 rx thr gone", A_RAW, 32'h01);
  endtask

  task automatic t_threshold();
    logic [31:0] d;
    wr(A_TXTHR, 3);
    for (int i = 0; i < 3; i++) wr(A_TXD, i);
    settle();
    chk("R6 tx level at thr", irq_raw[0], 1);
    wr(A_TXD, 3);
    settle();
    chk("R6 tx level above thr", irq_raw[0], 0);
    wr(A_RXTHR, 2);
    eng_push(1); eng_push(2);
    settle();
    chk("R6 rx level at thr", irq_raw[4], 0);
    eng_push(3);
    settle();
    chk("R6 rx level above thr", irq_raw[4], 1);
    rd(A_RXD, d);
    settle();
    chk("R6 rx follows level", irq_raw[4], 0);
    drain_tx(4);
    drain_rx(2);
    wr(A_TXTHR, 0);
    wr(A_RXTHR, 0);
  endtask

  task automatic t_thr_width();
    wr(A_TXTHR, DEPTH - 1);
    rd_chk("R7 thr depth-1", A_TXTHR, DEPTH - 1);
    wr(A_TXTHR, DEPTH);
    rd_chk("R7 thr depth wraps", A_TXTHR, 0);
    wr(A_TXTHR, DEPTH + 1);
    rd_chk("R7 thr depth+1", A_TXTHR, 1);
    wr(A_TXTHR, 0);
  endtask

  task automatic t_mask();
    settle();
    chk("R9 mask zero irq", irq, 0);
    wr(A_MASK, 32'h01);
    settle();
    chk("R9 irq on", irq, 1);
    chk("R9 masked", irq_masked, 32'h01);
    rd_chk("R9 masked reg", A_MSKD, 32'h01);
    wr(A_MASK, 32'h10);
    settle();
    chk("R9 irq masked off", irq, 0);
    eng_push(16'h55);
    settle();
    chk("R9 rx thr irq", irq, 1);
    chk("R9 masked rx", irq_masked, 32'h10);
    drain_rx(1);
    wr(A_MASK, 0);
    settle();
    chk("R9 irq off", irq, 0);
  endtask

  task automatic t_dma();
    logic [31:0] d;
    settle();
    chk("R10 dma off", {dma_tx_req, dma_rx_req}, 0);
    wr(A_DTXLVL, 2);
    wr(A_DMAEN, 32'h2);
    settle();
    chk("R10 tx req low level", dma_tx_req, 1);
    for (int i = 0; i < 3; i++) wr(A_TXD, i);
    settle();
    chk("R10 tx req above lvl", dma_tx_req, 0);
    wr(A_DRXLVL, 1);
    eng_push(7); eng_push(8);
    settle();
    chk("R10 rx req disabled", dma_rx_req, 0);
    wr(A_DMAEN, 32'h3);
    settle();
    chk("R10 rx req on", dma_rx_req, 1);
    rd(A_RXD, d);
    settle();
    chk("R10 rx req at lvl", dma_rx_req, 0);
    drain_rx(1);
    drain_tx(3);
    wr(A_DMAEN, 0);
  endtask

  task automatic t_disable();
    logic [31:0] d;
    wr(A_TXD, 1); wr(A_TXD, 2);
    eng_push(3); eng_push(4);
    wr(A_CLR, 32'h1);
    wr(A_CTRL, 0);
    rd_chk("R11 tx flushed", A_TXLVL, 0);
    rd_chk("R11 rx flushed", A_RXLVL, 0);
    chk("R11 avail off", eng_tx_avail, 0);
    for (int i = 0; i < DEPTH + 1; i++) begin
      wr(A_TXD, i);
      eng_push(W'(i));
    end
    rd(A_RXD, d);
    settle();
    chk("R11 no events", irq_raw, 0);
    rd_chk("R11 tx ignored", A_TXLVL, 0);
    rd_chk("R11 rx ignored", A_RXLVL, 0);
    wr(A_CTRL, 1);
  endtask

  task automatic t_busy();
    logic [W-1:0] d;
    rd_chk("R12 idle", A_STAT, 32'h0C);
    eng_busy = 1'b1;
    rd_chk("R12 engine busy", A_STAT, 32'h0D);
    eng_busy = 1'b0;
    wr(A_TXD, 9);
    rd_chk("R12 tx data busy", A_STAT, 32'h09);
    eng_pop(d);
    chk("R2 single pop", d, 9);
    rd_chk("R12 idle again", A_STAT, 32'h0C);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_tx_fill_overflow();
    t_rx_path();
    t_rx_errors();
    t_clear();
    t_threshold();
    t_thr_width();
    t_mask();
    t_dma();
    t_disable();
    t_busy();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule